// File: doc/BRIEF.md
# Instruction Category Mix Counter

This block watches the stream of retired instruction words from a 32-bit core and sorts every valid word into one of five categories by examining the top-level format bits and the secondary opcode fields. Each category owns a saturating counter. Software reads back the counters to see which kind of work a thread is currently doing: memory traffic, floating point, branching, machine-state manipulation, or plain integer arithmetic.

Counting is armed and disarmed by single-cycle start and stop pulses. It can also be restricted to instructions whose program counter lies in an inclusive address window. One clear pulse zeroes every counter at once. Any counter can be read through a small select-and-data port.

Top module: `imix_counter`

## Requirements
- R1: A word whose bits [31:30] equal 2'b11 (memory access format) is counted in category 0.
- R2: A word with bits [31:30] = 2'b10 and bits [24:19] equal to 6'h34 or 6'h35 (floating-point operate) is counted in category 1.
- R3: The following words are counted in category 2 (control flow): any word with bits [31:30] = 2'b01 (call); a word with bits [31:30] = 2'b00 and bits [24:22] equal to 3'b010, 3'b110 or 3'b111 (conditional branches); and a word with bits [31:30] = 2'b10 and bits [24:19] equal to 6'h38 or 6'h39 (register-indirect jump, trap return).
- R4: A word with bits [31:30] = 2'b10 and bits [24:19] in 6'h28..6'h2B, 6'h30..6'h33 or 6'h3A..6'h3D (state-register reads and writes, software trap, flush, window save and restore) is counted in category 3.
- R5: Every other word, including sethi, unimplemented and unassigned encodings, is counted in category 4 (integer ALU and catch-all).
- R6: `rd_data` shows, in the same cycle, the counter selected by `rd_sel` for values 0 to 4, and shows zero for values 5 to 7.
- R7: A valid word is counted only when the run state was already set before the edge. A `start` pulse sets the run state from the next edge on. A `stop` pulse clears it. When both pulses come in the same cycle, `stop` wins.
- R8: While `range_en` is 1, a word is counted only if `range_lo <= instr_pc <= range_hi`, with both bounds inclusive.
- R9: A `clr` pulse zeroes all counters at the next edge. A valid word in the same cycle as the clear is not counted.
- R10: A counter that reaches 2^CNT_W-1 holds that value until it is cleared.
- R11: After reset all counters read zero and the run state is cleared.
- R12: In any cycle at most one counter changes, and it changes by exactly one (clear excepted).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction word is valid this cycle |
| instr_word | input | 32 | Retired instruction word |
| instr_pc | input | ADDR_W | Address of the instruction |
| start | input | 1 | Pulse: enable counting from next cycle |
| stop | input | 1 | Pulse: disable counting |
| range_en | input | 1 | Restrict counting to the address window |
| range_lo | input | ADDR_W | Lower inclusive window bound |
| range_hi | input | ADDR_W | Upper inclusive window bound |
| clr | input | 1 | Pulse: zero all counters |
| rd_sel | input | 3 | Counter select for readout |
| rd_data | output | CNT_W | Selected counter value |

## Verification
Two pairs of controls can land on the same edge. A clear can arrive together with a valid instruction, and a start pulse can arrive together with a stop pulse. The bench drives a memory word with `clr` high and then expects every category to read zero. It raises `start` and `stop` together, follows with a valid word, and expects that word to be left uncounted. A start pulse that coincides with a valid word is also checked: that word must not be counted.

// File: rtl/imix_pkg.sv
package imix_pkg;
   localparam int NUM_CAT = 5;
   localparam int SEL_W   = 3;
   localparam int INSTR_W = 32;

   typedef enum logic [2:0] {
      CAT_MEM  = 3'd0,
      CAT_FP   = 3'd1,
      CAT_CTRL = 3'd2,
      CAT_SPEC = 3'd3,
      CAT_ALU  = 3'd4
   } cat_e;
endpackage

// File: rtl/imix_classifier.sv
module imix_classifier
   import imix_pkg::*;
(
   input  logic [1:0] fmt,
   input  logic [2:0] op2,
   input  logic [5:0] op3,
   output cat_e       cat
);
   logic is_fp, is_jump, is_spec, is_bcc;

   always_comb begin
      is_fp   = (op3 == 6'h34) || (op3 == 6'h35);
      is_jump = (op3 == 6'h38) || (op3 == 6'h39);
      is_spec = (op3[5:2] == 4'b1010) || (op3[5:2] == 4'b1100) ||
                ((op3 >= 6'h3A) && (op3 <= 6'h3D));
      is_bcc  = (op2 == 3'b010) || (op2 == 3'b110) || (op2 == 3'b111);
   end

   always_comb begin
      cat = CAT_ALU;
      case (fmt)
         2'b11: cat = CAT_MEM;
         2'b01: cat = CAT_CTRL;
         2'b00: if (is_bcc) cat = CAT_CTRL;
         default: begin
            if (is_fp)        cat = CAT_FP;
            else if (is_jump) cat = CAT_CTRL;
            else if (is_spec) cat = CAT_SPEC;
         end
      endcase
   end
endmodule

// File: rtl/imix_gate.sv
module imix_gate #(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              stop,
   input  logic              valid,
   input  logic              clr,
   input  logic [ADDR_W-1:0] pc,
   input  logic              range_en,
   input  logic [ADDR_W-1:0] lo,
   input  logic [ADDR_W-1:0] hi,
   output logic              run,
   output logic              count_en
);
   logic in_window;

   always_ff @(posedge clk) begin
      if (!rst_n)     run <= 1'b0;
      else if (stop)  run <= 1'b0;
      else if (start) run <= 1'b1;
   end

   always_comb begin
      in_window = !range_en || ((pc >= lo) && (pc <= hi));
      count_en  = run && valid && in_window && !clr;
   end
endmodule

// File: rtl/imix_sat_ctr.sv
module imix_sat_ctr #(
   parameter int CNT_W    = 32,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [CNT_W-1:0] cnt
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   generate
      if (SATURATE) begin : g_sat
         always_ff @(posedge clk) begin
            if (!rst_n || clr)            cnt <= '0;
            else if (inc && (cnt != '1))  cnt <= cnt + ONE;
         end
      end else begin : g_wrap
         always_ff @(posedge clk) begin
            if (!rst_n || clr) cnt <= '0;
            else if (inc)      cnt <= cnt + ONE;
         end
      end
   endgenerate
endmodule

// File: rtl/imix_counter.sv
module imix_counter
   import imix_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int CNT_W    = 32,
   parameter bit SATURATE = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               instr_valid,
   input  logic [INSTR_W-1:0] instr_word,
   input  logic [ADDR_W-1:0]  instr_pc,
   input  logic               start,
   input  logic               stop,
   input  logic               range_en,
   input  logic [ADDR_W-1:0]  range_lo,
   input  logic [ADDR_W-1:0]  range_hi,
   input  logic               clr,
   input  logic [SEL_W-1:0]   rd_sel,
   output logic [CNT_W-1:0]   rd_data
);
   generate
      if (CNT_W < 2 || CNT_W > 64) begin : g_bad_cnt_w
         $error("imix_counter: CNT_W must lie in 2..64");
      end
      if (ADDR_W < 1 || ADDR_W > 64) begin : g_bad_addr_w
         $error("imix_counter: ADDR_W must lie in 1..64");
      end
      if ((1 << SEL_W) < NUM_CAT) begin : g_bad_sel_w
         $error("imix_counter: SEL_W too narrow for NUM_CAT");
      end
   endgenerate

   cat_e                          cat;
   logic                          run_q;
   logic                          count_en;
   logic [NUM_CAT-1:0]            inc_vec;
   logic [NUM_CAT-1:0][CNT_W-1:0] cnt_q;
   logic                          unused_bits;

   assign unused_bits = ^{instr_word[29:25], instr_word[18:0]};

   imix_classifier u_cls (
      .fmt (instr_word[31:30]),
      .op2 (instr_word[24:22]),
      .op3 (instr_word[24:19]),
      .cat (cat)
   );

   imix_gate #(.ADDR_W(ADDR_W)) u_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .stop     (stop),
      .valid    (instr_valid),
      .clr      (clr),
      .pc       (instr_pc),
      .range_en (range_en),
      .lo       (range_lo),
      .hi       (range_hi),
      .run      (run_q),
      .count_en (count_en)
   );

   for (genvar i = 0; i < NUM_CAT; i++) begin : g_cat
      assign inc_vec[i] = count_en && (cat == cat_e'(i));

      imix_sat_ctr #(.CNT_W(CNT_W), .SATURATE(SATURATE)) u_ctr (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (clr),
         .inc   (inc_vec[i]),
         .cnt   (cnt_q[i])
      );
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NUM_CAT; i++) begin
         if (rd_sel == SEL_W'(i)) rd_data = cnt_q[i];
      end
   end
endmodule

// File: rtl/imix_checker.sv
module imix_checker #(
   parameter int ADDR_W   = 32,
   parameter int CNT_W    = 32,
   parameter int NUM_CAT  = 5,
   parameter bit SATURATE = 1'b1
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          clr,
   input logic                          run,
   input logic                          range_en,
   input logic [ADDR_W-1:0]             pc,
   input logic [ADDR_W-1:0]             lo,
   input logic [ADDR_W-1:0]             hi,
   input logic [NUM_CAT-1:0][CNT_W-1:0] cnt
);
   logic [NUM_CAT-1:0][CNT_W-1:0] prev_q;
   logic [NUM_CAT-1:0]            chg;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= cnt;
   end

   always_comb begin
      for (int i = 0; i < NUM_CAT; i++) chg[i] = (cnt[i] != prev_q[i]);
   end

   AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0)); // R9

   AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !clr) |=> $stable(cnt)); // R7

   AST_OUT_OF_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      (range_en && ((pc < lo) || (pc > hi)) && !clr) |=> $stable(cnt)); // R8

   AST_SINGLE_MOVER: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> $onehot0(chg)); // R12

   for (genvar i = 0; i < NUM_CAT; i++) begin : g_chk
      AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
         !clr |=> (!chg[i] || (cnt[i] == prev_q[i] + CNT_W'(1)))); // R12

      if (SATURATE) begin : g_sat
         AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            ((cnt[i] == '1) && !clr) |=> (cnt[i] == '1)); // R10
      end
   end
endmodule

bind imix_counter imix_checker #(
   .ADDR_W   (ADDR_W),
   .CNT_W    (CNT_W),
   .NUM_CAT  (imix_pkg::NUM_CAT),
   .SATURATE (SATURATE)
) u_imix_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .clr      (clr),
   .run      (run_q),
   .range_en (range_en),
   .pc       (instr_pc),
   .lo       (range_lo),
   .hi       (range_hi),
   .cnt      (cnt_q)
);

// File: tb/tb_imix_counter.sv
`timescale 1ns/1ps
module tb_imix_counter;
   import imix_pkg::*;

   localparam int CW = 4;
   localparam int AW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          instr_valid = 1'b0;
   logic [31:0]   instr_word = '0;
   logic [AW-1:0] instr_pc = '0;
   logic          start = 1'b0, stop = 1'b0, clr = 1'b0;
   logic          range_en = 1'b0;
   logic [AW-1:0] range_lo = '0, range_hi = '0;
   logic [2:0]    rd_sel = '0;
   logic [CW-1:0] rd_data;

   always #2.5 clk = ~clk;

   imix_counter #(.ADDR_W(AW), .CNT_W(CW)) dut (.*);

   typedef struct {
      int            sel;
      logic [CW-1:0] val;
      string         tag;
   } exp_t;

   exp_t          sb[$];
   exp_t          cur;
   logic [CW-1:0] model [NUM_CAT];
   bit            m_run = 1'b0;
   int            total = 0, bad = 0;
   bit            done = 1'b0;

   function automatic logic [31:0] f3(logic [1:0] op, logic [5:0] op3);
      return {op, 5'd0, op3, 19'd0};
   endfunction
   function automatic logic [31:0] f2(logic [2:0] op2);
      return {2'b00, 5'd0, op2, 22'd0};
   endfunction

   // driver: applies one cycle of stimulus and updates the expected model
   task automatic step(bit v, logic [31:0] w, logic [AW-1:0] pc, int cat,
                       bit st = 0, bit sp = 0, bit c = 0);
      bit inr;
      @(posedge clk); #1;
      instr_valid = v; instr_word = w; instr_pc = pc;
      start = st; stop = sp; clr = c;
      inr = !range_en || ((pc >= range_lo) && (pc <= range_hi));
      if (c) begin
         for (int k = 0; k < NUM_CAT; k++) model[k] = '0;
      end else if (m_run && v && inr && (model[cat] != '1)) begin
         model[cat] = model[cat] + 1'b1;
      end
      if (sp) m_run = 1'b0;
      else if (st) m_run = 1'b1;
   endtask

   task automatic idle();
      step(0, 32'h0, '0, 0);
   endtask

   // driver: selects a counter and pushes the expected readout
   task automatic rd(int s, string tag);
      exp_t e;
      @(posedge clk); #1;
      instr_valid = 0; start = 0; stop = 0; clr = 0;
      rd_sel = s[2:0];
      e.sel = s;
      e.val = (s < NUM_CAT) ? model[s] : '0;
      e.tag = tag;
      sb.push_back(e);
   endtask

   // monitor: compares readout against the scoreboard away from the edge
   initial begin
      forever begin
         @(negedge clk);
         if (sb.size() > 0) begin
            cur = sb.pop_front();
            total++;
            if (rd_data !== cur.val) begin
               bad++;
               $display("FAIL %s sel=%0d actual=%0d expected=%0d",
                        cur.tag, cur.sel, rd_data, cur.val);
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      for (int k = 0; k < NUM_CAT; k++) model[k] = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R11 reset state, R6 out-of-range select
      for (int k = 0; k < NUM_CAT; k++) rd(k, "R11");
      rd(5, "R6");
      rd(7, "R6");

      // R7 stopped: nothing counted; start coinciding with a word not counted
      step(1, f3(2'b11, 6'h00), 32'h40, 0);
      step(1, f3(2'b11, 6'h00), 32'h44, 0, 1);
      rd(0, "R7");

      // R12 single word moves only its own counter
      step(1, f3(2'b11, 6'h00), 32'h48, 0);
      for (int k = 0; k < NUM_CAT; k++) rd(k, "R12");

      // mixed stream covering every category
      step(1, f3(2'b11, 6'h04), 32'h4C, 0);  // R1 store
      step(1, f3(2'b10, 6'h34), 32'h50, 1);  // R2
      step(1, f3(2'b10, 6'h35), 32'h54, 1);  // R2
      step(1, {2'b01, 30'h123}, 32'h58, 2);  // R3 call
      step(1, f2(3'b010), 32'h5C, 2);        // R3
      step(1, f2(3'b110), 32'h60, 2);        // R3
      step(1, f2(3'b111), 32'h64, 2);        // R3
      step(1, f3(2'b10, 6'h38), 32'h68, 2);  // R3
      step(1, f3(2'b10, 6'h39), 32'h6C, 2);  // R3
      step(1, f3(2'b10, 6'h28), 32'h70, 3);  // R4
      step(1, f3(2'b10, 6'h33), 32'h74, 3);  // R4
      step(1, f3(2'b10, 6'h3A), 32'h78, 3);  // R4
      step(1, f3(2'b10, 6'h3B), 32'h7C, 3);  // R4
      step(1, f3(2'b10, 6'h3C), 32'h80, 3);  // R4
      step(1, f3(2'b10, 6'h3D), 32'h84, 3);  // R4
      step(1, f3(2'b10, 6'h00), 32'h88, 4);  // R5 add
      step(1, f2(3'b100), 32'h8C, 4);        // R5 sethi
      step(1, f2(3'b000), 32'h90, 4);        // R5 unimp
      step(1, f3(2'b10, 6'h3E), 32'h94, 4);  // R5 unassigned
      step(1, f3(2'b10, 6'h2C), 32'h98, 4);  // R5
      rd(0, "R1"); rd(1, "R2"); rd(2, "R3"); rd(3, "R4"); rd(4, "R5");

      // R8 inclusive address window
      idle();
      range_lo = 32'h100; range_hi = 32'h1FF; range_en = 1'b1;
      step(1, f3(2'b10, 6'h34), 32'h0FF, 1);
      step(1, f3(2'b10, 6'h34), 32'h100, 1);
      step(1, f3(2'b10, 6'h34), 32'h1FF, 1);
      step(1, f3(2'b10, 6'h34), 32'h200, 1);
      rd(1, "R8");
      range_en = 1'b0;

      // R9 clear wins over a same-cycle word
      step(1, f3(2'b11, 6'h00), 32'hA0, 0, 0, 0, 1);
      for (int k = 0; k < NUM_CAT; k++) rd(k, "R9");

      // R7 start and stop together: stop wins
      step(0, 32'h0, '0, 0, 1, 1);
      step(1, f3(2'b10, 6'h00), 32'hA4, 4);
      rd(4, "R7");

      // R10 saturation
      step(0, 32'h0, '0, 0, 1);
      for (int n = 0; n < 20; n++) step(1, {2'b01, 30'h0}, 32'hB0, 2);
      rd(2, "R10");
      step(1, {2'b01, 30'h0}, 32'hB4, 2);
      rd(2, "R10");

      // R7 stop halts counting
      step(0, 32'h0, '0, 0, 0, 1);
      step(1, f3(2'b10, 6'h00), 32'hB8, 4);
      rd(4, "R7");

      repeat (4) @(posedge clk);
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule